// File: doc/BRIEF.md
# Chipset Power Mode Controller

This block tracks which of four power modes a line-interface chipset is in: reset, normal, sleep or deep power-down. Software selects a mode by writing two control bits into a mode register over a simple register write bus. Before it honours a request, the block checks that request against the status of the three clock-generator registers. A request that fails this check is refused, the mode stays as it was, and a sticky error flag is raised.

From the current mode the block derives three enables. One is for the isolation link, one for the ring-detect output and one for the second clock stage. The low-power modes cannot be left by any register write. The only way out is a low level on the active-low reset pin, and that level counts only while the master clock is reported present. A reset always brings the block back to reset mode and clears the error flag.

The reset pin is sampled synchronously and also serves as the power-on reset of the block. The current mode is reported on a 2-bit output.

Top module: `chipPowerModeCtl`

## Requirements
- R1: On a clock edge where rstPinN is low and clkPresent is high, the block enters reset mode. From the next cycle modeOut is 0, linkEn and ringEn are low, stage2En is high and errFlag is low.
- R2: Only a write with regWrEn high and regAddr equal to 6 is a mode request. Bit 3 of regWrData is the PDN-like power-down bit and bit 4 is the link-hold bit. Writes to any other address, and all other data bits, have no effect.
- R3: In reset or normal mode, a mode request with bits 4 and 3 both clear moves the block to normal mode (modeOut 1), with linkEn, ringEn and stage2En high.
- R4: In reset or normal mode, a mode request with bit 4 set and bit 3 clear moves the block to reset mode (modeOut 0), with linkEn and ringEn low and stage2En high.
- R5: In reset or normal mode, a mode request with bit 3 set and bit 4 clear moves the block to sleep mode (modeOut 2) when all three bits of clkRegNonzero are high. In sleep mode linkEn, ringEn and stage2En are high.
- R6: A sleep request made while any bit of clkRegNonzero is low sets errFlag and leaves the mode unchanged.
- R7: In reset or normal mode, a mode request with bits 4 and 3 both set moves the block to deep power-down (modeOut 3) when clkRegNonzero bit 2 (third clock register) is low. In deep power-down linkEn, ringEn and stage2En are all low.
- R8: A deep power-down request made while clkRegNonzero bit 2 is high sets errFlag and leaves the mode unchanged.
- R9: In sleep or deep power-down, mode requests have no effect. Only the reset pin leaves these modes.
- R10: A low rstPinN on an edge where clkPresent is low has no effect. If rstPinN is still low on the first edge where clkPresent is high again, the reset takes effect on that edge.
- R11: Once set, errFlag stays high until a reset taken per R1. Later accepted mode changes do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstPinN | input | 1 | Active-low reset pin, sampled synchronously and qualified by clkPresent |
| clkPresent | input | 1 | High while the master clock is running |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register write address |
| regWrData | input | 8 | Register write data |
| clkRegNonzero | input | 3 | Per clock register: high when it holds a nonzero value (bit 0 first register, bit 2 third, second-stage register) |
| modeOut | output | 2 | Current mode: 0 reset, 1 normal, 2 sleep, 3 deep power-down |
| linkEn | output | 1 | Isolation link enable |
| ringEn | output | 1 | Ring-detect output enable |
| stage2En | output | 1 | Second clock stage enable |
| errFlag | output | 1 | Sticky flag for refused mode requests |

## Verification
The bench builds the block with its default parameters: mode register at address 6, control bits at positions 3 and 4, three clock-status bits, and the second-stage register at index 2. With these values a single data byte reaches every combination of the two control bits, and each refusal path can be exercised by clearing one status bit. The bench also drives the reset pin against a missing master clock, both with a pulse that ends before the clock returns and with a level held across its return. Mode requests are written inside both low-power modes to show they are ignored.

// File: rtl/pwrModePkg.sv
package pwrModePkg;

  typedef enum logic [1:0] {
    MODE_RESET  = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_SLEEP  = 2'd2,
    MODE_DEEP   = 2'd3
  } pwrMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     clearAll;    // reset taken: return outputs and flag to reset values
    logic     loadMode;    // accepted request: update enables from nextMode
    logic     flagReject;  // refused request: set sticky error
    pwrMode_t nextMode;
  } modeStrobe_t;

endpackage

// File: rtl/pwrModeDatapath.sv
module pwrModeDatapath
  import pwrModePkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int MODE_ADDR    = 6,
  parameter int PDN_BIT      = 3,
  parameter int PDL_BIT      = 4,
  parameter int NUM_CLK_REGS = 3,
  parameter int STAGE2_IDX   = 2
) (
  input  logic                    clk,
  input  logic                    rstPinN,
  input  logic                    clkPresent,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  input  logic [NUM_CLK_REGS-1:0] clkRegNonzero,
  input  modeStrobe_t             strobe,
  output logic                    wakeReset,
  output logic                    modeWrite,
  output logic                    reqPdn,
  output logic                    reqPdl,
  output logic                    sleepOk,
  output logic                    deepOk,
  output logic                    linkEn,
  output logic                    ringEn,
  output logic                    stage2En,
  output logic                    errFlag
);

  localparam logic [ADDR_W-1:0] ModeAddrL = ADDR_W'(MODE_ADDR);

  // running AND across the clock-register status bits
  logic [NUM_CLK_REGS:0] allNonzeroChain;
  assign allNonzeroChain[0] = 1'b1;
  for (genvar gi = 0; gi < NUM_CLK_REGS; gi++) begin : g_nzChain
    assign allNonzeroChain[gi+1] = allNonzeroChain[gi] & clkRegNonzero[gi];
  end

  assign wakeReset = !rstPinN && clkPresent;
  assign modeWrite = regWrEn && (regAddr == ModeAddrL);
  assign reqPdn    = regWrData[PDN_BIT];
  assign reqPdl    = regWrData[PDL_BIT];
  assign sleepOk   = allNonzeroChain[NUM_CLK_REGS];
  assign deepOk    = !clkRegNonzero[STAGE2_IDX];

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      errFlag  <= 1'b0;
      linkEn   <= 1'b0;
      ringEn   <= 1'b0;
      stage2En <= 1'b1;
    end else begin
      if (strobe.flagReject) errFlag <= 1'b1;
      if (strobe.loadMode) begin
        linkEn   <= (strobe.nextMode == MODE_NORMAL) || (strobe.nextMode == MODE_SLEEP);
        ringEn   <= (strobe.nextMode == MODE_NORMAL) || (strobe.nextMode == MODE_SLEEP);
        stage2En <= (strobe.nextMode != MODE_DEEP);
      end
    end
  end

endmodule

// File: rtl/pwrModeCtrl.sv
module pwrModeCtrl
  import pwrModePkg::*;
(
  input  logic        clk,
  input  logic        wakeReset,
  input  logic        modeWrite,
  input  logic        reqPdn,
  input  logic        reqPdl,
  input  logic        sleepOk,
  input  logic        deepOk,
  output pwrMode_t    modeQ,
  output modeStrobe_t strobe
);

  logic awake;
  assign awake = (modeQ == MODE_RESET) || (modeQ == MODE_NORMAL);

  always_comb begin
    strobe          = '0;
    strobe.nextMode = modeQ;
    if (wakeReset) begin
      strobe.clearAll = 1'b1;
      strobe.nextMode = MODE_RESET;
    end else if (modeWrite && awake) begin
      unique case ({reqPdl, reqPdn})
        2'b00: begin
          strobe.loadMode = 1'b1;
          strobe.nextMode = MODE_NORMAL;
        end
        2'b10: begin
          strobe.loadMode = 1'b1;
          strobe.nextMode = MODE_RESET;
        end
        2'b01: begin
          if (sleepOk) begin
            strobe.loadMode = 1'b1;
            strobe.nextMode = MODE_SLEEP;
          end else begin
            strobe.flagReject = 1'b1;
          end
        end
        default: begin
          if (deepOk) begin
            strobe.loadMode = 1'b1;
            strobe.nextMode = MODE_DEEP;
          end else begin
            strobe.flagReject = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll)      modeQ <= MODE_RESET;
    else if (strobe.loadMode) modeQ <= strobe.nextMode;
  end

endmodule

// File: rtl/chipPowerModeCtl.sv
module chipPowerModeCtl
  import pwrModePkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int MODE_ADDR    = 6,
  parameter int PDN_BIT      = 3,
  parameter int PDL_BIT      = 4,
  parameter int NUM_CLK_REGS = 3,
  parameter int STAGE2_IDX   = 2
) (
  input  logic                    clk,
  input  logic                    rstPinN,
  input  logic                    clkPresent,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  input  logic [NUM_CLK_REGS-1:0] clkRegNonzero,
  output logic [1:0]              modeOut,
  output logic                    linkEn,
  output logic                    ringEn,
  output logic                    stage2En,
  output logic                    errFlag
);

  modeStrobe_t strobe;
  pwrMode_t    modeQ;
  logic wakeReset, modeWrite, reqPdn, reqPdl, sleepOk, deepOk;

  pwrModeDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR),
    .PDN_BIT(PDN_BIT), .PDL_BIT(PDL_BIT),
    .NUM_CLK_REGS(NUM_CLK_REGS), .STAGE2_IDX(STAGE2_IDX)
  ) uDatapath (
    .clk(clk), .rstPinN(rstPinN), .clkPresent(clkPresent),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .clkRegNonzero(clkRegNonzero), .strobe(strobe),
    .wakeReset(wakeReset), .modeWrite(modeWrite),
    .reqPdn(reqPdn), .reqPdl(reqPdl), .sleepOk(sleepOk), .deepOk(deepOk),
    .linkEn(linkEn), .ringEn(ringEn), .stage2En(stage2En), .errFlag(errFlag)
  );

  pwrModeCtrl uCtrl (
    .clk(clk), .wakeReset(wakeReset), .modeWrite(modeWrite),
    .reqPdn(reqPdn), .reqPdl(reqPdl), .sleepOk(sleepOk), .deepOk(deepOk),
    .modeQ(modeQ), .strobe(strobe)
  );

  assign modeOut = modeQ;

endmodule

// File: rtl/pwrModeChecker.sv
module pwrModeChecker #(
  parameter int NUM_CLK_REGS = 3,
  parameter int STAGE2_IDX   = 2
) (
  input logic                    clk,
  input logic                    rstPinN,
  input logic                    clkPresent,
  input logic [NUM_CLK_REGS-1:0] clkRegNonzero,
  input logic [1:0]              modeOut,
  input logic                    linkEn,
  input logic                    ringEn,
  input logic                    stage2En,
  input logic                    errFlag
);

  logic resetTake;
  logic armed = 1'b0;
  assign resetTake = !rstPinN && clkPresent;

  always_ff @(posedge clk) armed <= armed | resetTake;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rstPinN && !armed)
    resetTake |=> (modeOut == 2'd0) && !linkEn && !ringEn && stage2En && !errFlag);

  p_link_ring_r3: assert property (@(posedge clk) disable iff (!armed || resetTake)
    (linkEn == ((modeOut == 2'd1) || (modeOut == 2'd2))) && (ringEn == linkEn));

  p_sleep_guard_r6: assert property (@(posedge clk) disable iff (!armed || resetTake)
    ((modeOut == 2'd2) && ($past(modeOut) != 2'd2)) |-> (&$past(clkRegNonzero)));

  p_deep_guard_r8: assert property (@(posedge clk) disable iff (!armed || resetTake)
    ((modeOut == 2'd3) && ($past(modeOut) != 2'd3)) |-> !$past(clkRegNonzero[STAGE2_IDX]));

  p_deep_off_r7: assert property (@(posedge clk) disable iff (!armed || resetTake)
    (modeOut == 2'd3) |-> (!linkEn && !ringEn && !stage2En));

  p_lowpower_hold_r9: assert property (@(posedge clk) disable iff (!armed || resetTake)
    (modeOut[1] && !resetTake) |=> (modeOut == $past(modeOut)));

  p_no_wake_noclk_r10: assert property (@(posedge clk) disable iff (!armed || resetTake)
    (modeOut[1] && !clkPresent) |=> modeOut[1]);

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!armed || resetTake)
    (errFlag && !resetTake) |=> errFlag);

endmodule

bind chipPowerModeCtl pwrModeChecker #(
  .NUM_CLK_REGS(NUM_CLK_REGS), .STAGE2_IDX(STAGE2_IDX)
) chk (
  .clk(clk), .rstPinN(rstPinN), .clkPresent(clkPresent),
  .clkRegNonzero(clkRegNonzero), .modeOut(modeOut), .linkEn(linkEn),
  .ringEn(ringEn), .stage2En(stage2En), .errFlag(errFlag)
);

// File: tb/tb_chipPowerModeCtl.sv
module tb_chipPowerModeCtl;

  logic       clk = 1'b0;
  logic       rstPinN = 1'b1;
  logic       clkPresent = 1'b1;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [2:0] clkRegNonzero = 3'b111;
  logic [1:0] modeOut;
  logic       linkEn, ringEn, stage2En, errFlag;

  always #5 clk = ~clk;

  chipPowerModeCtl dut (
    .clk(clk), .rstPinN(rstPinN), .clkPresent(clkPresent),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .clkRegNonzero(clkRegNonzero), .modeOut(modeOut), .linkEn(linkEn),
    .ringEn(ringEn), .stage2En(stage2En), .errFlag(errFlag)
  );

  typedef struct {
    logic [5:0] vec;  // {mode[1:0], link, ring, stage2, err}
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference state built from the requirements
  logic [1:0] mMode = 2'd0;
  logic       mErr  = 1'b0;

  task automatic step(input logic rN, input logic cp, input logic we,
                      input logic [3:0] a, input logic [7:0] d,
                      input logic [2:0] nz, input string tag);
    expItem_t it;
    @(negedge clk);
    rstPinN = rN; clkPresent = cp; regWrEn = we;
    regAddr = a; regWrData = d; clkRegNonzero = nz;
    if (!rN && cp) begin
      mMode = 2'd0; mErr = 1'b0;
    end else if (we && a == 4'd6 && mMode < 2'd2) begin
      case ({d[4], d[3]})
        2'b00: mMode = 2'd1;
        2'b10: mMode = 2'd0;
        2'b01: if (&nz) mMode = 2'd2; else mErr = 1'b1;
        default: if (!nz[2]) mMode = 2'd3; else mErr = 1'b1;
      endcase
    end
    @(posedge clk);
    #1;
    it.vec = {mMode, (mMode == 2'd1 || mMode == 2'd2), (mMode == 2'd1 || mMode == 2'd2),
              (mMode != 2'd3), mErr};
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare one queued expectation per cycle, between edges
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      logic [5:0] act;
      it = expQ.pop_front();
      act = {modeOut, linkEn, ringEn, stage2En, errFlag};
      checks++;
      if (act !== it.vec) begin
        failures++;
        $display("FAIL %s: actual mode/link/ring/stage2/err=%b expected=%b", it.tag, act, it.vec);
      end
    end
  end

  initial begin
    step(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, 3'b111, "R1 reset state");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h00, 3'b111, "R3 enter normal");
    step(1'b1, 1'b1, 1'b1, 4'd5, 8'h18, 3'b011, "R2 other address ignored");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h10, 3'b111, "R4 back to reset mode");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h00, 3'b111, "R3 normal again");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h08, 3'b011, "R6 sleep refused");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h08, 3'b111, "R5 sleep entered, R11 err kept");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h00, 3'b111, "R9 write in sleep ignored");
    step(1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 3'b111, "R10 reset without clock ignored");
    step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, 3'b111, "R10 pulse ended before clock");
    step(1'b1, 1'b1, 1'b0, 4'd0, 8'h00, 3'b111, "R10 clock back, no wake");
    step(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, 3'b111, "R1 wake from sleep, R11 err cleared");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h00, 3'b111, "R3 normal after wake");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h18, 3'b100, "R8 deep refused");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h18, 3'b011, "R7 deep entered");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h00, 3'b011, "R9 write in deep ignored");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'h10, 3'b011, "R9 reset-mode write in deep ignored");
    step(1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 3'b011, "R10 held low without clock");
    step(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, 3'b011, "R10 held low, clock returns");
    step(1'b1, 1'b1, 1'b1, 4'd6, 8'hE7, 3'b111, "R2 other data bits ignored");
    step(1'b1, 1'b1, 1'b0, 4'd0, 8'h00, 3'b111, "R3 normal idle");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule